// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the interrupt core of an eight-input programmable interrupt controller. Each request line is captured into a pending register, either on a rising edge or by following the level of the line. It is then filtered by a mask and compared in priority against the levels already in service. When an unmasked request outranks everything in service, `int_o` rises toward the processor.

A single-cycle acknowledge pulse moves the winning request from pending to in-service. The same pulse latches an 8-bit vector formed from a 5-bit base and the 3-bit level. A poll pulse does the same work but returns a status byte instead of a vector.

End-of-interrupt, rotation and set-priority commands arrive as one-cycle strobes from an external command decoder. The priority order is a ring whose lowest-priority position can be moved. Automatic end-of-interrupt mode can optionally rotate the ring on every acknowledge.

Top module: `prio_intr_resolver`

## Requirements
- R1: After reset the pending and in-service registers are zero, `int_o`, `vector_o` and `poll_data_o` are zero, and the priority order has level 0 highest and level 7 lowest.
- R2: With `level_mode_i` low, a rising edge on a request line sets its pending bit, which stays set after the line falls until acknowledged; a line held high after acknowledge is not captured again.
- R3: With `level_mode_i` high, the pending register follows the lines one cycle later, so a line still high when its in-service bit is cleared raises `int_o` again.
- R4: A masked request never raises `int_o`, and masking does not clear its pending bit.
- R5: `int_o` is high when the highest-priority unmasked pending level outranks every in-service level. An acknowledge while `int_o` is high clears that pending bit and sets its in-service bit. In the next cycle `vector_o` = {`vec_base_i`, level}. An acknowledge while `int_o` is low changes no state and returns level 7.
- R6: With `sfnm_i` high, a request at the same level as the highest in-service level also raises `int_o`.
- R7: Command code 3'b001 (non-specific EOI) clears the highest-priority set in-service bit.
- R8: Command code 3'b011 (specific EOI) clears the in-service bit named by `cmd_level_i`.
- R9: Command code 3'b101 clears the highest-priority in-service bit and makes that level lowest priority. Command code 3'b111 does the same for the level in `cmd_level_i`.
- R10: Command code 3'b110 makes `cmd_level_i` the lowest priority, so the next level up (mod 8) is highest. Code 3'b010 does nothing.
- R11: With `aeoi_i` high, an acknowledge leaves the in-service register unchanged. Code 3'b100 turns on rotation in this mode, so each acknowledged level becomes lowest priority. Code 3'b000 turns that rotation off.
- R12: With `special_mask_i` high, masked in-service levels do not block lower-priority requests.
- R13: A poll pulse acts as an acknowledge. In the next cycle `poll_data_o` is 8'h80 | level when a request qualified, else 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Request lines |
| level_mode_i | input | 1 | 1: level capture, 0: edge capture |
| aeoi_i | input | 1 | Automatic end-of-interrupt mode |
| sfnm_i | input | 1 | Equal-level nesting allowed |
| special_mask_i | input | 1 | Masked in-service levels do not block |
| mask_i | input | 8 | Per-line mask, 1 = masked |
| vec_base_i | input | 5 | Upper five bits of the vector |
| inta_i | input | 1 | Acknowledge pulse |
| poll_i | input | 1 | Poll pulse |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_level_i | input | 3 | Command level operand |
| int_o | output | 1 | Interrupt request to processor |
| vector_o | output | 8 | Vector latched on acknowledge |
| poll_data_o | output | 8 | Status latched on poll |
| irr_o | output | 8 | Pending register |
| isr_o | output | 8 | In-service register |

## Verification
The bench sweeps every one of the 256 request patterns at each of the eight lowest-priority positions and checks the winning vector against a ring-order model. A wrong rotation offset or a scan in the wrong direction therefore shows up as a wrong level. It targets nesting: a lower level blocked and a higher level passed, and the equal-level case that only equal-level nesting mode allows. A design that compared priority by raw index instead of ring position would fail those cases. It also covers the difference between non-specific and specific EOI, rotation by both EOI forms and by automatic EOI, and a level-mode line held through EOI, which must interrupt again. It covers an edge-mode line held high, which must not. The special mask case and spurious acknowledge check that masked in-service bits stop blocking only when asked. They also check that an acknowledge with nothing qualifying leaves state untouched.

// File: rtl/prio_intr_pkg.sv
package prio_intr_pkg;
  localparam int NUM_IRQ  = 8;
  localparam int LVL_W    = $clog2(NUM_IRQ);
  localparam int VEC_W    = 8;
  localparam int VBASE_W  = VEC_W - LVL_W;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [2:0] {
    CMD_ROT_AEOI_CLR = 3'b000,
    CMD_NS_EOI       = 3'b001,
    CMD_NOP          = 3'b010,
    CMD_SP_EOI       = 3'b011,
    CMD_ROT_AEOI_SET = 3'b100,
    CMD_ROT_NS_EOI   = 3'b101,
    CMD_SET_PRIO     = 3'b110,
    CMD_ROT_SP_EOI   = 3'b111
  } cmd_e;

  // 0 = highest priority given the current lowest-priority level
  function automatic lvl_t rank_of(lvl_t lvl, lvl_t lowest);
    return lvl_t'(lvl - lowest - lvl_t'(1));
  endfunction
endpackage

// File: rtl/prio_irq_capture.sv
module prio_irq_capture #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic         level_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q, irr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        irr_q  <= 1'b0;
      end else begin
        prev_q <= irq_i[g];
        if (level_mode_i)            irr_q <= irq_i[g] & ~clr_i[g];
        else if (clr_i[g])           irr_q <= 1'b0;
        else if (irq_i[g] && !prev_q) irr_q <= 1'b1;
      end
    end
    assign irr_o[g] = irr_q;
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] lowest_i,
  output logic          found_o,
  output logic [LW-1:0] lvl_o
);
  // scan ring from lowest+1 upward; nearest set bit wins
  always_comb begin
    found_o = 1'b0;
    lvl_o   = lowest_i;
    for (int i = N - 1; i >= 0; i--) begin
      logic [LW-1:0] idx;
      idx = LW'(lowest_i + LW'(1) + LW'(i));
      if (vec_i[idx]) begin
        found_o = 1'b1;
        lvl_o   = idx;
      end
    end
  end
endmodule

// File: rtl/prio_intr_resolver.sv
module prio_intr_resolver
  import prio_intr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               level_mode_i,
  input  logic               aeoi_i,
  input  logic               sfnm_i,
  input  logic               special_mask_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  input  logic [VBASE_W-1:0] vec_base_i,
  input  logic               inta_i,
  input  logic               poll_i,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_op_i,
  input  logic [LVL_W-1:0]   cmd_level_i,
  output logic               int_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic [VEC_W-1:0]   poll_data_o,
  output logic [NUM_IRQ-1:0] irr_o,
  output logic [NUM_IRQ-1:0] isr_o
);
  logic [NUM_IRQ-1:0] irr, isr_q, isr_n, pend, blk, clr;
  lvl_t               lowest_q, lowest_n;
  logic               rot_aeoi_q, rot_aeoi_n;
  logic [VEC_W-1:0]   vector_q, poll_q;

  logic req_found, blk_found, top_found;
  lvl_t req_lvl, blk_lvl, top_lvl;
  logic int_cond, take;

  prio_irq_capture #(.N(NUM_IRQ)) u_cap (
    .clk_i, .rst_ni, .irq_i, .level_mode_i,
    .clr_i (clr),
    .irr_o (irr)
  );

  assign pend = irr & ~mask_i;
  assign blk  = special_mask_i ? (isr_q & ~mask_i) : isr_q;

  prio_pick #(.N(NUM_IRQ)) u_req (.vec_i(pend),  .lowest_i(lowest_q), .found_o(req_found), .lvl_o(req_lvl));
  prio_pick #(.N(NUM_IRQ)) u_blk (.vec_i(blk),   .lowest_i(lowest_q), .found_o(blk_found), .lvl_o(blk_lvl));
  prio_pick #(.N(NUM_IRQ)) u_top (.vec_i(isr_q), .lowest_i(lowest_q), .found_o(top_found), .lvl_o(top_lvl));

  always_comb begin
    int_cond = 1'b0;
    if (req_found) begin
      if (!blk_found)                                            int_cond = 1'b1;
      else if (rank_of(req_lvl, lowest_q) < rank_of(blk_lvl, lowest_q)) int_cond = 1'b1;
      else if (sfnm_i && req_lvl == blk_lvl)                     int_cond = 1'b1;
    end
  end

  assign take = (inta_i | poll_i) & int_cond;

  always_comb begin
    clr = '0;
    if (take) clr[req_lvl] = 1'b1;
  end

  always_comb begin
    isr_n      = isr_q;
    lowest_n   = lowest_q;
    rot_aeoi_n = rot_aeoi_q;
    if (cmd_valid_i) begin
      unique case (cmd_e'(cmd_op_i))
        CMD_NS_EOI:       if (top_found) isr_n[top_lvl] = 1'b0;
        CMD_SP_EOI:       isr_n[cmd_level_i] = 1'b0;
        CMD_ROT_NS_EOI: begin
          if (top_found) begin
            isr_n[top_lvl] = 1'b0;
            lowest_n       = top_lvl;
          end
        end
        CMD_ROT_SP_EOI: begin
          isr_n[cmd_level_i] = 1'b0;
          lowest_n           = cmd_level_i;
        end
        CMD_SET_PRIO:     lowest_n   = cmd_level_i;
        CMD_ROT_AEOI_SET: rot_aeoi_n = 1'b1;
        CMD_ROT_AEOI_CLR: rot_aeoi_n = 1'b0;
        default: ;
      endcase
    end
    if (take) begin
      if (!aeoi_i)         isr_n[req_lvl] = 1'b1;
      else if (rot_aeoi_q) lowest_n       = req_lvl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q      <= '0;
      lowest_q   <= lvl_t'(NUM_IRQ - 1);
      rot_aeoi_q <= 1'b0;
      vector_q   <= '0;
      poll_q     <= '0;
    end else begin
      isr_q      <= isr_n;
      lowest_q   <= lowest_n;
      rot_aeoi_q <= rot_aeoi_n;
      if (inta_i) vector_q <= {vec_base_i, take ? req_lvl : lvl_t'(NUM_IRQ - 1)};
      if (poll_i) poll_q   <= int_cond ? {1'b1, {(VEC_W-1-LVL_W){1'b0}}, req_lvl} : '0;
    end
  end

  assign int_o       = int_cond;
  assign vector_o    = vector_q;
  assign poll_data_o = poll_q;
  assign irr_o       = irr;
  assign isr_o       = isr_q;
endmodule

// File: rtl/prio_intr_checker.sv
module prio_intr_checker
  import prio_intr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               inta_i,
  input logic               poll_i,
  input logic               aeoi_i,
  input logic [NUM_IRQ-1:0] mask_i,
  input logic [VBASE_W-1:0] vec_base_i,
  input logic               cmd_valid_i,
  input logic [2:0]         cmd_op_i,
  input logic [LVL_W-1:0]   cmd_level_i,
  input logic               int_o,
  input logic [VEC_W-1:0]   vector_o,
  input logic [NUM_IRQ-1:0] irr_o,
  input logic [NUM_IRQ-1:0] isr_o
);
  assert_int_unmasked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (|(irr_o & ~mask_i)));

  assert_ack_sets_isr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && !aeoi_i && !cmd_valid_i) |=> $countones(isr_o) == $countones($past(isr_o)) + 1);

  assert_vector_base_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> vector_o[VEC_W-1:LVL_W] == $past(vec_base_i));

  assert_aeoi_keeps_isr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && aeoi_i && !cmd_valid_i) |=> isr_o == $past(isr_o));

  assert_ns_eoi_one_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'b001 && (|isr_o) && !inta_i && !poll_i)
      |=> $countones(isr_o) == $countones($past(isr_o)) - 1);

  assert_sp_eoi_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'b011 && !inta_i && !poll_i) |=> !isr_o[$past(cmd_level_i)]);
endmodule

bind prio_intr_resolver prio_intr_checker u_chk (.*);

// File: tb/sim_prio_intr_resolver.sv
module sim_prio_intr_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0, mask = '0;
  logic       lvl_mode = 1'b1, aeoi = 1'b0, sfnm = 1'b0, smask = 1'b0;
  logic [4:0] vbase = 5'h15;
  logic       inta = 1'b0, poll = 1'b0, cv = 1'b0;
  logic [2:0] cop = '0, clvl = '0;
  logic       int_w;
  logic [7:0] vec_w, poll_w, irr_w, isr_w;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_intr_resolver u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .level_mode_i(lvl_mode), .aeoi_i(aeoi),
    .sfnm_i(sfnm), .special_mask_i(smask), .mask_i(mask), .vec_base_i(vbase),
    .inta_i(inta), .poll_i(poll), .cmd_valid_i(cv), .cmd_op_i(cop), .cmd_level_i(clvl),
    .int_o(int_w), .vector_o(vec_w), .poll_data_o(poll_w), .irr_o(irr_w), .isr_o(isr_w));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic ack();
    inta = 1'b1; step(); inta = 1'b0;
  endtask

  task automatic do_poll();
    poll = 1'b1; step(); poll = 1'b0;
  endtask

  task automatic cmd(logic [2:0] op, logic [2:0] l);
    cv = 1'b1; cop = op; clvl = l; step(); cv = 1'b0;
  endtask

  function automatic int winner(logic [7:0] pat, int lowest);
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = (lowest + 1 + i) % 8;
      if (pat[idx]) return idx;
    end
    return 7;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1; step();
    // R1 reset state
    chk("R1 int", int_w, 0); chk("R1 irr", irr_w, 0); chk("R1 isr", isr_w, 0);
    chk("R1 vector", vec_w, 0); chk("R1 poll", poll_w, 0);
    irq = 8'hFF; step();
    ack(); chk("R1 default highest", vec_w, 8'hA8);
    cmd(3'b011, 3'd0); irq = 0; step();

    // R5/R10 exhaustive sweep over lowest position and request pattern
    for (int lp = 0; lp < 8; lp++) begin
      cmd(3'b110, 3'(lp));
      for (int pat = 0; pat < 256; pat++) begin
        int w;
        irq = 8'(pat); step();
        chk("R5 int", int_w, (pat != 0) ? 1 : 0);
        if (pat != 0) begin
          w = winner(8'(pat), lp);
          ack();
          chk("R10 vector", vec_w, {5'h15, 3'(w)});
          chk("R5 isr", isr_w, 1 << w);
          cmd(3'b011, 3'(w));
        end
        irq = 0; step();
      end
    end
    cmd(3'b110, 3'd7);
    cmd(3'b010, 3'd3);
    irq = 8'hFF; step(); ack();
    chk("R10 nop keeps order", vec_w, 8'hA8);
    cmd(3'b011, 3'd0); irq = 0; step();

    // R5 spurious acknowledge
    ack();
    chk("R5 spurious vector", vec_w, 8'hAF); chk("R5 spurious isr", isr_w, 0);

    // R4 masking
    mask = 8'h10; irq = 8'h10; step(); step();
    chk("R4 masked int", int_w, 0); chk("R4 irr kept", irr_w, 8'h10);
    ack(); chk("R4 masked ack isr", isr_w, 0);
    mask = 0; step(); chk("R4 unmask int", int_w, 1);
    irq = 0; step();

    // R5/R6 nesting
    irq = 8'h08; step(); ack();
    irq = 8'h28; step(); chk("R5 lower blocked", int_w, 0);
    irq = 8'h0A; step(); chk("R5 higher passes", int_w, 1);
    irq = 8'h08; step(); chk("R6 equal blocked", int_w, 0);
    sfnm = 1'b1; step(); chk("R6 equal sfnm", int_w, 1);
    sfnm = 1'b0;
    irq = 8'h02; step(); ack(); chk("R5 nested isr", isr_w, 8'h0A);
    irq = 0;
    cmd(3'b001, 3'd0); chk("R7 ns eoi", isr_w, 8'h08);
    cmd(3'b011, 3'd3); chk("R8 sp eoi", isr_w, 8'h00);

    // R3 level capture
    irq = 8'h40; step(); ack(); step();
    chk("R3 blocked", int_w, 0); chk("R3 irr follows", irr_w, 8'h40);
    cmd(3'b011, 3'd6); chk("R3 second int", int_w, 1);
    irq = 0; step(); step(); chk("R3 line low", int_w, 0);

    // R2 edge capture
    lvl_mode = 1'b0;
    irq = 8'h04; step(); irq = 0; step();
    chk("R2 latched", irr_w, 8'h04); chk("R2 int", int_w, 1);
    ack(); chk("R2 isr", isr_w, 8'h04); chk("R2 irr clr", irr_w, 0);
    cmd(3'b011, 3'd2);
    irq = 8'h04; step(); ack(); cmd(3'b011, 3'd2); step(); step();
    chk("R2 held no relatch", irr_w, 0); chk("R2 held int", int_w, 0);
    irq = 0; step();
    lvl_mode = 1'b1;

    // R9 rotations
    irq = 8'h20; step(); ack(); irq = 0; step();
    cmd(3'b101, 3'd0); chk("R9 rot ns isr", isr_w, 0);
    irq = 8'hFF; step(); ack(); chk("R9 rot ns order", vec_w, 8'hAE);
    cmd(3'b011, 3'd6); irq = 0; step();
    irq = 8'h01; step(); ack(); irq = 0; step();
    cmd(3'b111, 3'd0); chk("R9 rot sp isr", isr_w, 0);
    irq = 8'hFF; step(); ack(); chk("R9 rot sp order", vec_w, 8'hA9);
    cmd(3'b011, 3'd1); irq = 0; step();
    cmd(3'b110, 3'd7);

    // R11 automatic EOI
    aeoi = 1'b1;
    irq = 8'h10; step(); ack();
    chk("R11 aeoi isr", isr_w, 0); chk("R11 aeoi vector", vec_w, 8'hAC);
    irq = 0; step();
    cmd(3'b100, 3'd0);
    irq = 8'h04; step(); ack(); irq = 0; step();
    irq = 8'hFF; step(); ack(); chk("R11 rotate aeoi", vec_w, 8'hAB);
    irq = 0; step();
    cmd(3'b000, 3'd0);
    irq = 8'h02; step(); ack(); irq = 0; step();
    irq = 8'hFF; step(); ack(); chk("R11 rotate off", vec_w, 8'hAC);
    irq = 0; step();
    aeoi = 1'b0;
    cmd(3'b110, 3'd7);

    // R12 special mask
    irq = 8'h01; step(); ack();
    irq = 8'h20; step(); mask = 8'h01; step();
    chk("R12 no smask", int_w, 0);
    smask = 1'b1; step(); chk("R12 smask int", int_w, 1);
    ack(); chk("R12 smask isr", isr_w, 8'h21);
    smask = 1'b0; mask = 0; irq = 0; step();
    cmd(3'b011, 3'd0); cmd(3'b011, 3'd5); chk("R8 both clear", isr_w, 0);

    // R13 poll
    irq = 8'h48; step(); do_poll();
    chk("R13 poll data", poll_w, 8'h83); chk("R13 poll isr", isr_w, 8'h08);
    irq = 0; step(); cmd(3'b011, 3'd3);
    do_poll(); chk("R13 poll empty", poll_w, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule